// File: doc/BRIEF.md
# Prescaler with retrigger alignment

This block produces the clock enable that paces a timer's main counter and decides the cycle in which a retrigger event is allowed to clear or reload that counter. A three-bit division code picks one of eight non-uniform ratios: powers of two up to 16, then 64, 256 and 1024. A single internal count runs from zero up to the ratio minus one. It emits a one-cycle tick enable as it wraps. While the counter is not running, the count is held at zero.

A retrigger pulse is turned into a one-cycle reload strobe according to a two-bit alignment mode. The strobe can follow the raw clock, or it can wait for the next prescaled tick. A third mode follows the raw clock and also restarts the prescaler, so the next tick comes a full period later. The fourth code is spare and acts like the raw-clock mode. The main counter itself, the compare logic and the event routing live outside this block.

Top module: `presc_retrig`

## Requirements
- R1: Division code values 0,1,2,3,4,5,6,7 select ratios 1,2,4,8,16,64,256,1024. While running, the tick enable is high for exactly one cycle in every ratio cycles.
- R2: With division code 0 (ratio 1), the tick enable is high in every cycle in which running is high.
- R3: The tick enable is high in the cycle in which the internal count equals ratio-1, and the count is 0 in the following cycle.
- R4: Alignment mode 0: a retrigger sampled high in cycle t gives a reload strobe high in cycle t+1 only.
- R5: Alignment mode 1: a retrigger is held until a cycle with the tick enable high (the retrigger's own cycle included), and the strobe is high in the cycle after that tick.
- R6: Alignment mode 1: any number of retriggers that arrive before the same tick give a single one-cycle strobe.
- R7: Alignment mode 2: a retrigger in cycle t gives a strobe in cycle t+1 and restarts the prescaler, so the next tick is in cycle t+ratio.
- R8: Alignment mode 3 behaves exactly as mode 0.
- R9: While running is low, the tick enable is low, the count is held at 0 and any held mode-1 retrigger is dropped. After running rises, the first tick is in the ratio-th running cycle.
- R10: Synchronous active-high reset clears the count, the held retrigger and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Division code |
| sync_mode | input | 2 | Retrigger alignment mode |
| retrig | input | 1 | Retrigger event, one sample per high cycle |
| running | input | 1 | Main counter is running |
| tick_en | output | 1 | Prescaled clock enable |
| reload_stb | output | 1 | Clear/reload strobe for the main counter |

## Verification
The embedded properties assume that the division code and the alignment mode stay constant while a period is in progress and while a mode-1 retrigger is held. Changing either one in the middle of a period leaves the period length and the strobe alignment undefined. The bench changes these settings only with running low, between phases. It applies retriggers as single-cycle pulses at chosen offsets. These offsets place some retriggers on a tick cycle and some between ticks, and put several retriggers inside one held window.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int LOG2_MAX_RATIO = 10;
    localparam int CNT_W          = LOG2_MAX_RATIO;
    localparam int SEL_W          = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ALIGN_RAW   = 2'd0,
        ALIGN_TICK  = 2'd1,
        ALIGN_RESYN = 2'd2,
        ALIGN_SPARE = 2'd3
    } align_e;

    // Shift amount for each division code: 0..4 linear, then steps of two.
    function automatic int unsigned ratio_log2(input logic [SEL_W-1:0] sel);
        if (sel < 3'd5) return int'(sel);
        else            return 6 + 2 * (int'(sel) - 5);
    endfunction

    function automatic cnt_t wrap_limit(input logic [SEL_W-1:0] sel);
        int unsigned sh;
        logic [CNT_W:0] full;
        sh   = ratio_log2(sel);
        full = (CNT_W+1)'(1) << sh;
        return cnt_t'(full - 1'b1);
    endfunction

    typedef struct packed {
        logic held;
        logic strobe;
    } align_state_t;

endpackage

// File: rtl/presc_divider.sv
module presc_divider
    import presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             running,
    input  logic             restart,
    output logic             tick,
    output cnt_t             count
);
    cnt_t limit;
    cnt_t cnt_q;

    assign limit = wrap_limit(div_sel);
    assign tick  = running && (cnt_q == limit);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (!running)     cnt_q <= '0;
        else if (restart)      cnt_q <= '0;
        else if (cnt_q >= limit) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !running |=> (cnt_q == '0));

    p_wrap_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/retrig_align.sv
module retrig_align
    import presc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  align_e mode,
    input  logic   retrig,
    input  logic   running,
    input  logic   tick,
    output logic   restart,
    output logic   strobe
);
    align_state_t st_q, st_d;

    always_comb begin
        st_d    = '0;
        restart = 1'b0;
        unique case (mode)
            ALIGN_TICK: begin
                st_d.strobe = tick && (st_q.held || retrig);
                st_d.held   = running && !tick && (st_q.held || retrig);
            end
            ALIGN_RESYN: begin
                st_d.strobe = retrig;
                restart     = retrig;
            end
            default: begin
                st_d.strobe = retrig;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign strobe = st_q.strobe;

    p_raw_next_r4: assert property (@(posedge clk) disable iff (rst)
        ((mode == ALIGN_RAW) && retrig) |=> strobe);

    p_spare_next_r8: assert property (@(posedge clk) disable iff (rst)
        ((mode == ALIGN_SPARE) && retrig) |=> strobe);

    p_no_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !running |=> !st_q.held);

endmodule

// File: rtl/presc_retrig.sv
module presc_retrig
    import presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] div_sel,
    input  logic [1:0] sync_mode,
    input  logic       retrig,
    input  logic       running,
    output logic       tick_en,
    output logic       reload_stb
);
    logic   tick_w;
    logic   restart_w;
    cnt_t   count_w;
    align_e mode_w;

    assign mode_w = align_e'(sync_mode);

    presc_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .running (running),
        .restart (restart_w),
        .tick    (tick_w),
        .count   (count_w)
    );

    retrig_align u_align (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_w),
        .retrig  (retrig),
        .running (running),
        .tick    (tick_w),
        .restart (restart_w),
        .strobe  (reload_stb)
    );

    assign tick_en = tick_w;

    p_resync_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ((sync_mode == 2'd2) && retrig && running) |=> (count_w == '0));

    p_tick_gated_r5: assert property (@(posedge clk) disable iff (rst)
        ((sync_mode == 2'd1) && !tick_en) |=> !reload_stb);

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (reload_stb && (sync_mode == 2'd1) && (div_sel != 3'd0)) |=> !reload_stb);

    p_every_clock_r2: assert property (@(posedge clk) disable iff (rst)
        ((div_sel == 3'd0) && running) |-> tick_en);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !reload_stb);

endmodule

// File: tb/sim_presc_retrig.sv
`timescale 1ns/1ps
module sim_presc_retrig;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] div_sel;
    logic [1:0] sync_mode;
    logic       retrig;
    logic       running;
    logic       tick_en;
    logic       reload_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // behavioural model state
    int m_cnt    = 0;
    bit m_held   = 0;
    bit m_strobe = 0;

    always #5 clk = ~clk;

    presc_retrig u0 (
        .clk        (clk),
        .rst        (rst),
        .div_sel    (div_sel),
        .sync_mode  (sync_mode),
        .retrig     (retrig),
        .running    (running),
        .tick_en    (tick_en),
        .reload_stb (reload_stb)
    );

    function automatic int ratio_for(input int code);
        case (code)
            0: return 1;    1: return 2;    2: return 4;    3: return 8;
            4: return 16;   5: return 64;   6: return 256;  default: return 1024;
        endcase
    endfunction

    function automatic string tick_tag();
        if (rst)            return "R10";
        if (!running)       return "R9";
        if (div_sel == 3'd0) return "R2";
        return "R1 R3";
    endfunction

    function automatic string strobe_tag();
        if (rst) return "R10";
        case (sync_mode)
            2'd0: return "R4";
            2'd1: return "R5 R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called just after a falling edge with inputs already driven.
    task automatic step();
        int  r;
        bit  exp_tick;
        bit  nxt_strobe;
        bit  nxt_held;
        #1;
        r        = ratio_for(int'(div_sel));
        exp_tick = running && !rst && (m_cnt == r - 1);
        check(tick_tag(),   "tick_en",    tick_en,    exp_tick);
        check(strobe_tag(), "reload_stb", reload_stb, m_strobe);
        // next state
        nxt_held = 0;
        if (sync_mode == 2'd1) begin
            nxt_strobe = exp_tick && (m_held || retrig);
            nxt_held   = running && !exp_tick && (m_held || retrig);
        end else begin
            nxt_strobe = retrig;
        end
        if (rst) begin
            m_cnt = 0; m_held = 0; m_strobe = 0;
        end else begin
            if (!running)                           m_cnt = 0;
            else if (sync_mode == 2'd2 && retrig)   m_cnt = 0;
            else if (m_cnt >= r - 1)                m_cnt = 0;
            else                                    m_cnt = m_cnt + 1;
            m_held   = nxt_held;
            m_strobe = nxt_strobe;
        end
        @(negedge clk);
    endtask

    // One phase: settings applied with running low, then n running cycles.
    // Retrigger pulses at offsets a, b, c (negative = unused).
    // Running drops for the last cycles when stop_at >= 0.
    task automatic phase(input int code, input int mode, input int n,
                         input int a, input int b, input int c, input int stop_at);
        running = 1'b0; retrig = 1'b0;
        div_sel = 3'(code); sync_mode = 2'(mode);
        step();
        step();
        running = 1'b1;
        for (int i = 0; i < n; i++) begin
            retrig  = (i == a) || (i == b) || (i == c);
            running = !(stop_at >= 0 && i >= stop_at);
            step();
        end
        retrig = 1'b0; running = 1'b0;
        step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst = 1'b1; running = 1'b0; retrig = 1'b1;
        div_sel = 3'd3; sync_mode = 2'd0;
        @(negedge clk);
        // R10: strobe low and count cleared throughout reset
        step();
        step();
        retrig = 1'b0;
        step();
        rst = 1'b0;
        step();
        // R1 R2 R3 R4: every ratio in raw-clock mode, one retrigger
        for (int code = 0; code < 8; code++)
            phase(code, 0, 3 * ratio_for(code) + 6, 7, -1, -1, -1);
        // R5 R6: tick-aligned, two merged pulses, then one on a tick cycle (ratio 8: ticks at 7, 15, 23)
        phase(3, 1, 40, 2, 4, 15, -1);
        // R5 with ratio 1 and ratio 16
        phase(0, 1, 12, 3, 4, -1, -1);
        phase(4, 1, 60, 1, 9, 33, -1);
        // R7: resync restarts prescaler (ratio 16)
        phase(4, 2, 80, 5, 30, 31, -1);
        phase(2, 2, 30, 2, 11, -1, -1);
        // R8: spare mode equals raw mode
        phase(2, 3, 30, 0, 6, 7, -1);
        // R9: held retrigger dropped when running falls (ratio 64)
        phase(5, 1, 50, 3, -1, -1, 20);
        phase(5, 1, 140, -1, -1, -1, -1);
        summary();
    end

endmodule